// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and an asynchronous 512K-word by 16-bit static RAM that has separate lower and upper byte lanes. The host offers one request at a time over a valid/ready handshake: a word address, write data, a two-bit lane mask and a write flag. The controller plays out the chip-select, write-enable, output-enable and lane-enable sequence for that request, one clock-counted phase at a time. For reads, it returns the captured word with a one-cycle valid pulse.

Every strobe comes from a register. The lengths of the read-access wait, the write-enable pulse and the minimum spacing between accepted requests are integer parameters, set from the memory's speed grade and the clock period. The defaults fit a 70 ns part with a 10 ns clock. The data bus is split into an output word, an input word and a drive-enable. The controller drives the bus only while the memory's own outputs are held off.

Top module: `sram_port_ctrl`

## Requirements
- R1: During and directly after reset, `req_ready` is 1, `rsp_valid` is 0, `mem_dq_oe` is 0, and all five memory strobes are high.
- R2: A read holds chip select and output enable low, with write enable high, for exactly RD_WAIT cycles. The word on `mem_dq_in` is registered at the clock edge that ends the last of those cycles. `rsp_valid` is high for exactly the one cycle after that edge.
- R3: Mask bit 0 set to 1 disables the lower lane (bits 7:0, `mem_lb_n`). Mask bit 1 set to 1 disables the upper lane (bits 15:8, `mem_ub_n`). A disabled lane's enable stays high for the whole access, and that lane reads back as zero in `rsp_rdata`. Both lane enables are high whenever chip select is high.
- R4: A write opens with one cycle in which chip select and the lane enables are low while write enable is still high. Write enable is then low for exactly WR_PULSE cycles. Output enable stays high for the whole write.
- R5: `mem_dq_oe` rises in the same cycle that write enable falls, and it falls one cycle after write enable rises. It is never high while output enable is low.
- R6: A write changes only the lanes its mask enables. The other lanes keep their earlier contents, as a later full-word read shows.
- R7: After a request is accepted, `req_ready` stays low for at least the next CYC_MIN-1 cycles. As a result, two acceptances are never fewer than CYC_MIN clock edges apart.
- R8: A request with mask 2'b11 asserts no strobe. A read with this mask still pulses `rsp_valid`, with data 0.
- R9: `mem_addr` holds the accepted address and does not change while chip select is low. This includes the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*LANE_W | Write data |
| req_bmask | input | 2 | Lane mask; 1 disables the lane (bit 0 lower, bit 1 upper) |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 2*LANE_W | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower-lane enable, active low |
| mem_ub_n | output | 1 | Upper-lane enable, active low |
| mem_dq_out | output | 2*LANE_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for `mem_dq_out` |
| mem_dq_in | input | 2*LANE_W | Data returned by the memory |

## Verification
The read-data pulse of one access lands in the same cycle that `req_ready` reopens. The next request is therefore accepted while the previous response is still on the port. The bench provokes this overlap by issuing each request as soon as ready is seen. It runs reads straight after writes and reads straight after reads. The scoreboard pops the expected word at that pulse and compares it, and lane, strobe-shape and spacing monitors check that the new access's strobes start cleanly next to it. The memory model returns garbage until RD_WAIT cycles of access have passed, and it drives a filler pattern on disabled lanes. An early capture or a leaked lane therefore shows up as a wrong word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WSETUP,
        PH_WPULSE,
        PH_WREC
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic lanes_on;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_REST = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                        lanes_on: 1'b0, drive: 1'b0};

    // Strobe levels that belong to each phase.
    function automatic strobe_t strobes_for(phase_e ph);
        strobe_t s;
        s = STROBE_REST;
        case (ph)
            PH_READ: begin
                s.cs_n = 1'b0; s.oe_n = 1'b0; s.lanes_on = 1'b1;
            end
            PH_WSETUP: begin
                s.cs_n = 1'b0; s.lanes_on = 1'b1;
            end
            PH_WPULSE: begin
                s.cs_n = 1'b0; s.we_n = 1'b0; s.lanes_on = 1'b1; s.drive = 1'b1;
            end
            PH_WREC: begin
                s.drive = 1'b1;
            end
            default: s = STROBE_REST;
        endcase
        return s;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CYC_MIN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic idle
);
    localparam int CNT_W = $clog2(CYC_MIN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC_MIN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> idle); // R7

endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_WAIT  = 7,
    parameter int WR_PULSE = 5
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_write,
    output phase_e phase_d,
    output phase_e phase_q,
    output logic   rd_last
);
    localparam int CNT_MAX = max2(RD_WAIT, WR_PULSE);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_PULSE - 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:   if (start) phase_d = start_write ? PH_WSETUP : PH_READ;
            PH_READ:   if (cnt_q == '0) phase_d = PH_IDLE;
            PH_WSETUP: phase_d = PH_WPULSE;
            PH_WPULSE: if (cnt_q == '0) phase_d = PH_WREC;
            PH_WREC:   phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_d != phase_q) begin
                if (phase_d == PH_READ)       cnt_q <= RD_LOAD;
                else if (phase_d == PH_WPULSE) cnt_q <= WR_LOAD;
                else                           cnt_q <= '0;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rd_last = (phase_q == PH_READ) && (cnt_q == '0);

    AST_READ_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        rd_last |=> (phase_q == PH_IDLE)); // R2
    AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WSETUP) |=> (phase_q == PH_WPULSE)); // R4
    AST_REC_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WREC) |-> ($past(phase_q) == PH_WPULSE)); // R4

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic                blank,
    input  logic [1:0]          lane_mask,
    input  logic [2*LANE_W-1:0] dq_in,
    output logic                rsp_valid,
    output logic [2*LANE_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (rst) rsp_valid <= 1'b0;
        else     rsp_valid <= capture || blank;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || blank) begin
                rsp_data[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rsp_data[g*LANE_W +: LANE_W] <= lane_mask[g] ? '0 : dq_in[g*LANE_W +: LANE_W];
            end
        end
    end

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R2

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LANE_W   = 8,
    parameter int RD_WAIT  = 7,
    parameter int WR_PULSE = 5,
    parameter int CYC_MIN  = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    input  logic [1:0]          req_bmask,
    output logic                rsp_valid,
    output logic [2*LANE_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_cs_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_lb_n,
    output logic                mem_ub_n,
    output logic [2*LANE_W-1:0] mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [2*LANE_W-1:0] mem_dq_in
);
    localparam int DATA_W = 2 * LANE_W;

    logic        accept, noop, timer_idle, rd_last;
    phase_e      phase_d, phase_q;
    strobe_t     strobe_d, strobe_q;
    logic [1:0]  mask_q, mask_d, be_n_q;

    assign accept    = req_valid && req_ready;
    assign noop      = &req_bmask;
    assign req_ready = timer_idle && (phase_q == PH_IDLE);
    assign mask_d    = accept ? req_bmask : mask_q;
    assign strobe_d  = strobes_for(phase_d);

    sram_cycle_timer #(.CYC_MIN(CYC_MIN)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .idle  (timer_idle)
    );

    sram_phase_seq #(.RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && !noop),
        .start_write (req_write),
        .phase_d     (phase_d),
        .phase_q     (phase_q),
        .rd_last     (rd_last)
    );

    sram_read_capture #(.LANE_W(LANE_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .capture   (rd_last),
        .blank     (accept && noop && !req_write),
        .lane_mask (mask_q),
        .dq_in     (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mask_q     <= '1;
            strobe_q   <= STROBE_REST;
            be_n_q     <= '1;
        end else begin
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata[DATA_W-1:0];
                mask_q     <= req_bmask;
            end
            strobe_q <= strobe_d;
            be_n_q   <= strobe_d.lanes_on ? mask_d : 2'b11;
        end
    end

    assign mem_cs_n  = strobe_q.cs_n;
    assign mem_we_n  = strobe_q.we_n;
    assign mem_oe_n  = strobe_q.oe_n;
    assign mem_dq_oe = strobe_q.drive;
    assign mem_lb_n  = be_n_q[0];
    assign mem_ub_n  = be_n_q[1];

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R5
    AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe); // R5
    AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |=> !mem_dq_oe); // R5
    AST_READ_SHAPE: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n)); // R2
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready); // R7
    AST_NOOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (accept && noop) |=> mem_cs_n); // R8
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R9
    AST_LANES_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (mem_lb_n && mem_ub_n)); // R3

endmodule

// File: tb/sram_port_ctrl_bench.sv
module sram_port_ctrl_bench;
    localparam int ADDR_W   = 19;
    localparam int RD_WAIT  = 7;
    localparam int WR_PULSE = 5;
    localparam int CYC_MIN  = 7;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hEEEE;

    sram_port_ctrl u_sram_port_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0, errors = 0;
    logic [15:0] store  [int];
    logic [15:0] shadow [int];
    logic [15:0] exp_q [$];
    logic [1:0]  cur_mask = 2'b11;
    logic [18:0] cur_addr = '0;

    int acc_cnt = 0, we_run = 0, oe_run = 0, since = 0, cs_low_total = 0;
    int pulse_bad = 0, setup_bad = 0, rd_bad = 0, dq_bad = 0, lane_bad = 0;
    int addr_bad = 0, ready_bad = 0, pulses = 0, reads_seen = 0;
    bit tracking = 1'b0;
    logic prev_we_n = 1'b1, prev_cs_n = 1'b1;
    logic [18:0] prev_addr = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] keep_lanes(logic [15:0] d, logic [1:0] m);
        logic [15:0] r = d;
        if (m[0]) r[7:0]  = 8'h00;
        if (m[1]) r[15:8] = 8'h00;
        return r;
    endfunction

    // Memory model, response scoreboard and strobe monitors.
    always @(negedge clk) begin
        logic [15:0] w;
        logic [15:0] rd;
        if (rst) begin
            acc_cnt = 0; we_run = 0; oe_run = 0; tracking = 1'b0;
            prev_we_n = 1'b1; prev_cs_n = 1'b1;
        end else begin
            if (!mem_cs_n && !mem_oe_n) acc_cnt++; else acc_cnt = 0;
            w = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : 16'h0000;
            if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                store[int'(mem_addr)] = w;
            end
            if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
                rd = (acc_cnt >= RD_WAIT) ? w : 16'h5A5A;
                if (mem_lb_n) rd[7:0]  = 8'hA5;
                if (mem_ub_n) rd[15:8] = 8'hA5;
                mem_dq_in = rd;
            end else begin
                mem_dq_in = 16'hEEEE;
            end

            if (rsp_valid) begin
                if (exp_q.size() == 0) check(1'b0, "R2 unexpected response", 32'(rsp_rdata), 0);
                else begin
                    rd = exp_q.pop_front();
                    check(rsp_rdata === rd, "R2/R3/R6 read data", 32'(rsp_rdata), 32'(rd));
                end
            end

            if (!mem_cs_n) cs_low_total++;
            if (!mem_we_n) we_run++;
            else if (!prev_we_n) begin
                pulses++;
                if (we_run != WR_PULSE) pulse_bad++;
                we_run = 0;
            end
            if (!mem_we_n && prev_we_n && prev_cs_n) setup_bad++;
            if (!mem_we_n && !mem_oe_n) setup_bad++;
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin
                reads_seen++;
                if (oe_run != RD_WAIT) rd_bad++;
                oe_run = 0;
            end
            if (mem_dq_oe != (!mem_we_n || !prev_we_n)) dq_bad++;
            if (mem_dq_oe && !mem_oe_n) dq_bad++;
            if (!mem_cs_n && ({mem_ub_n, mem_lb_n} != cur_mask)) lane_bad++;
            if (mem_cs_n && !(mem_lb_n && mem_ub_n)) lane_bad++;
            if (!mem_cs_n && (mem_addr != cur_addr)) addr_bad++;
            if (!mem_cs_n && !prev_cs_n && (mem_addr != prev_addr)) addr_bad++;
            if (tracking) begin
                since++;
                if (since < CYC_MIN && req_ready) ready_bad++;
                if (since >= CYC_MIN) tracking = 1'b0;
            end
            if (req_valid && req_ready) begin
                tracking = 1'b1;
                since = 0;
            end
            prev_we_n = mem_we_n;
            prev_cs_n = mem_cs_n;
            prev_addr = mem_addr;
        end
    end

    // Driver: waits for ready, presents one request, records expectations.
    task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] m);
        logic [15:0] old;
        int c0;
        do begin
            @(posedge clk); #1;
        end while (!req_ready);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        cur_mask = m; cur_addr = a;
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        if (wr) begin
            if (!m[0]) old[7:0]  = d[7:0];
            if (!m[1]) old[15:8] = d[15:8];
            shadow[int'(a)] = old;
        end else begin
            exp_q.push_back(keep_lanes(old, m));
        end
        c0 = cs_low_total;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (m == 2'b11) begin
            repeat (CYC_MIN + 2) @(negedge clk);
            check(cs_low_total == c0, "R8 no strobe on all-ones mask", 32'(cs_low_total), 32'(c0));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready === 1'b1, "R1 ready in reset", 32'(req_ready), 1);
        check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
        check({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} === 5'b11111,
              "R1 strobes high", 32'({mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 32'h1f);
        check(mem_dq_oe === 1'b0, "R1 drivers off", 32'(mem_dq_oe), 0);
        rst = 1'b0;

        // R2/R4: full-word write then read back
        issue(1'b1, 19'd5, 16'h1234, 2'b00);
        issue(1'b0, 19'd5, 16'h0000, 2'b00);
        // R6: lower-lane write keeps the upper lane
        issue(1'b1, 19'd5, 16'hFFAB, 2'b10);
        issue(1'b0, 19'd5, 16'h0000, 2'b00);
        // R6: upper-lane write keeps the lower lane
        issue(1'b1, 19'd5, 16'hCDFF, 2'b01);
        // R3: single-lane reads zero the disabled lane
        issue(1'b0, 19'd5, 16'h0000, 2'b01);
        issue(1'b0, 19'd5, 16'h0000, 2'b10);
        // R8: all-ones mask write leaves memory alone, read returns zero
        issue(1'b1, 19'd5, 16'h0000, 2'b11);
        issue(1'b0, 19'd5, 16'h0000, 2'b11);
        issue(1'b0, 19'd5, 16'h0000, 2'b00);
        // R9: address extremes back to back
        issue(1'b1, 19'h7FFFF, 16'hBEEF, 2'b00);
        issue(1'b1, 19'h00000, 16'h0F0F, 2'b00);
        issue(1'b0, 19'h7FFFF, 16'h0000, 2'b00);
        issue(1'b0, 19'h00000, 16'h0000, 2'b00);
        // Mixed patterns
        for (int i = 0; i < 16; i++)
            issue(1'b1, 19'(i * 4099 + 7), 16'(i * 16'h1357) ^ 16'hA0F0, 2'(i % 3));
        for (int i = 0; i < 16; i++)
            issue(1'b0, 19'(i * 4099 + 7), 16'h0000, 2'((i + 1) % 3));

        repeat (CYC_MIN + 4) @(negedge clk);
        check(exp_q.size() == 0, "R2 every read answered", 32'(exp_q.size()), 0);
        check(pulses > 0 && pulse_bad == 0, "R4 write pulse length", 32'(pulse_bad), 0);
        check(setup_bad == 0, "R4 setup cycle and output enable high", 32'(setup_bad), 0);
        check(reads_seen > 0 && rd_bad == 0, "R2 read window length", 32'(rd_bad), 0);
        check(dq_bad == 0, "R5 driver timing and no contention", 32'(dq_bad), 0);
        check(lane_bad == 0, "R3 lane enables follow mask", 32'(lane_bad), 0);
        check(addr_bad == 0, "R9 address stable under chip select", 32'(addr_bad), 0);
        check(ready_bad == 0, "R7 ready held low after acceptance", 32'(ready_bad), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule